// File: doc/BRIEF.md
# ADC master serial readout controller

This block is the digital sequencing and serial output stage of a 16-bit sampling converter. In this stage the converter supplies its own serial bit clock and acts as the serial master. A start pulse begins a conversion. A counter of fixed length stands in for the analog core. When that count ends, the 16-bit word on a sample input is captured as the result. The result then leaves on a serial data line, most significant bit first. Two signals go with it: a bit clock derived from the system clock, and a frame strobe that stays active for the whole word.

A mode input picks one of two timings. In read-after mode, the word is shifted out straight after its own conversion, and busy stays high until the last bit has gone. In read-during mode, the previous result is shifted out while the new conversion runs, and busy falls as soon as the conversion ends. Two invert inputs flip the bit clock and the frame strobe independently. An active-low read-enable gates all serial activity onto the pins.

Top module: `adc_serial_master`

## Requirements
- R1: A start pulse sampled while the block is idle raises busy on the next cycle. The conversion then takes CONV_CLKS cycles, and at its end the word on `sample_in` becomes the new result.
- R2: A frame is 16 bit periods long, and the frame strobe is active for the whole frame. The frame carries the frame word bit 15 first, down to bit 0. Outside a frame the data line is 0.
- R3: Each bit period lasts SCLK_DIV system clocks. The uninverted bit clock is low for the first SCLK_DIV/2 clocks of a period and high for the rest. Data changes only at the start of a period, so it is stable at the rising (active) clock edge.
- R4: With `read_during`=0 at start, the frame begins on the cycle after the conversion ends and carries that conversion's sample. Busy stays high for CONV_CLKS + 16*SCLK_DIV cycles in total and falls with the end of the frame.
- R5: With `read_during`=1 at start, the frame begins on the cycle after start and carries the previous result (0 after reset). Busy is high for exactly CONV_CLKS cycles.
- R6: A start pulse is ignored while busy is high or while a frame is still being shifted out.
- R7: `inv_sclk`=1 inverts the bit clock pin, and `inv_sync`=1 inverts the frame strobe pin. Each acts independently of the other.
- R8: While `cs_rd_n` is high, `sdout` is 0, `sclk` sits at its idle level (equal to `inv_sclk`) and `sync` is inactive (equal to `inv_sync`). The conversion and frame timing continue unchanged underneath.
- R9: During reset, busy is 0, `sdout` is 0, and `sclk` and `sync` are at their idle levels. The stored result is 0.
- R10: The mode is sampled at the accepted start. Changing `read_during` during a conversion or frame does not affect that operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Conversion start request, sampled each cycle |
| read_during | input | 1 | 0: read after conversion, 1: read previous result during conversion |
| inv_sclk | input | 1 | Invert the bit clock pin |
| inv_sync | input | 1 | Invert the frame strobe pin |
| cs_rd_n | input | 1 | Active-low gate for serial output |
| sample_in | input | 16 | Word taken as the result at the end of conversion |
| busy | output | 1 | Conversion (and, in read-after mode, readout) in progress |
| sclk | output | 1 | Serial bit clock |
| sync | output | 1 | Frame-valid strobe |
| sdout | output | 1 | Serial data, MSB first |

## Verification
The bench builds the block with SCLK_DIV=4 and CONV_CLKS=24. A divisor of 4 gives two-cycle clock halves, so every data change and every active edge land on separate sampled cycles. A 64-cycle frame is longer than a 24-cycle conversion. In read-during mode, busy therefore falls while the frame is still running, and a start sent in that gap exercises the rule that a start is also ignored during a frame. The short conversion keeps each sequence under a hundred cycles, which leaves room for both modes, all four polarity combinations that are used, and a frame with the read-enable dropped in the middle.

// File: rtl/adc_serial_master.sv
module adc_serial_master #(
  parameter int SCLK_DIV  = 4,
  parameter int CONV_CLKS = 40
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        read_during,
  input  logic        inv_sclk,
  input  logic        inv_sync,
  input  logic        cs_rd_n,
  input  logic [15:0] sample_in,
  output logic        busy,
  output logic        sclk,
  output logic        sync,
  output logic        sdout
);
  localparam int HALF = SCLK_DIV / 2;
  localparam int CW   = $clog2(CONV_CLKS + 1);
  localparam int DW   = $clog2(SCLK_DIV);

  logic          busy_q, conv_act, shift_act, mode_q;
  logic [CW-1:0] conv_cnt;
  logic [DW-1:0] div_cnt;
  logic [3:0]    bit_cnt;
  logic [15:0]   result_q, shreg;

  wire accept  = start && !busy_q && !shift_act;
  wire bit_end = shift_act && (div_cnt == DW'(SCLK_DIV - 1));
  wire rd_en   = !cs_rd_n;
  wire clk_raw = shift_act && (div_cnt >= DW'(HALF));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      conv_act  <= 1'b0;
      shift_act <= 1'b0;
      mode_q    <= 1'b0;
      conv_cnt  <= '0;
      div_cnt   <= '0;
      bit_cnt   <= '0;
      result_q  <= '0;
      shreg     <= '0;
    end else begin
      if (accept) begin
        conv_act <= 1'b1;
        conv_cnt <= CW'(CONV_CLKS - 1);
        busy_q   <= 1'b1;
        mode_q   <= read_during;
        if (read_during) begin
          shift_act <= 1'b1;
          shreg     <= result_q;
          div_cnt   <= '0;
          bit_cnt   <= '0;
        end
      end else if (conv_act) begin
        if (conv_cnt == '0) begin
          conv_act <= 1'b0;
          result_q <= sample_in;
          if (!mode_q) begin
            shift_act <= 1'b1;
            shreg     <= sample_in;
            div_cnt   <= '0;
            bit_cnt   <= '0;
          end else begin
            busy_q <= 1'b0;
          end
        end else begin
          conv_cnt <= conv_cnt - 1'b1;
        end
      end
      if (shift_act) begin
        if (bit_end) begin
          div_cnt <= '0;
          shreg   <= {shreg[14:0], 1'b0};
          bit_cnt <= bit_cnt + 1'b1;
          if (bit_cnt == 4'd15) begin
            shift_act <= 1'b0;
            if (!mode_q) busy_q <= 1'b0;
          end
        end else begin
          div_cnt <= div_cnt + 1'b1;
        end
      end
    end
  end

  assign busy  = busy_q;
  assign sclk  = (rd_en && clk_raw) ^ inv_sclk;
  assign sync  = (rd_en && shift_act) ^ inv_sync;
  assign sdout = rd_en && shift_act && shreg[15];
endmodule

module adc_serial_master_chk #(
  parameter int SCLK_DIV  = 4,
  parameter int CONV_CLKS = 40
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            cs_rd_n,
  input logic                            inv_sclk,
  input logic                            inv_sync,
  input logic                            sclk,
  input logic                            sync,
  input logic                            sdout,
  input logic                            busy_q,
  input logic                            conv_act,
  input logic                            shift_act,
  input logic                            mode_q,
  input logic [$clog2(CONV_CLKS+1)-1:0]  conv_cnt,
  input logic [$clog2(SCLK_DIV)-1:0]     div_cnt,
  input logic [15:0]                     shreg
);
  // R2
  data_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sdout |-> (sync != inv_sync));

  // R8
  gate_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rd_n |-> (!sdout && sclk == inv_sclk && sync == inv_sync));

  // R1
  conv_countdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_act && conv_cnt != '0) |=> (conv_act && conv_cnt == $past(conv_cnt) - 1'b1));

  // R3
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_act && div_cnt != ($clog2(SCLK_DIV))'(SCLK_DIV - 1)) |=> $stable(shreg));

  // R4
  busy_covers_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_act && !mode_q) |-> busy_q);

  // R5
  busy_ends_conv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_act && mode_q && !conv_act) |-> !busy_q);

  // R10
  mode_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q || shift_act) |=> $stable(mode_q));
endmodule

bind adc_serial_master adc_serial_master_chk #(
  .SCLK_DIV(SCLK_DIV), .CONV_CLKS(CONV_CLKS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_rd_n(cs_rd_n), .inv_sclk(inv_sclk),
  .inv_sync(inv_sync), .sclk(sclk), .sync(sync), .sdout(sdout),
  .busy_q(busy_q), .conv_act(conv_act), .shift_act(shift_act),
  .mode_q(mode_q), .conv_cnt(conv_cnt), .div_cnt(div_cnt), .shreg(shreg)
);

// File: tb/adc_serial_master_bench.sv
module adc_serial_master_bench;
  localparam int DIV   = 4;
  localparam int CONV  = 24;
  localparam int FRAME = 16 * DIV;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, start, read_during, inv_sclk, inv_sync, cs_rd_n;
  logic [15:0] sample_in;
  logic busy, sclk, sync, sdout;

  adc_serial_master #(.SCLK_DIV(DIV), .CONV_CLKS(CONV)) u_adc_serial_master (
    .clk(clk), .rst_n(rst_n), .start(start), .read_during(read_during),
    .inv_sclk(inv_sclk), .inv_sync(inv_sync), .cs_rd_n(cs_rd_n),
    .sample_in(sample_in), .busy(busy), .sclk(sclk), .sync(sync), .sdout(sdout)
  );

  integer checks = 0, bad = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // behavioural schedule model
  integer n, f0, conv_end, busy_end;
  bit mode_m, exp_busy, exp_shift, prev_shift, e_raw, e_bit, raw_prev, clean;
  logic [15:0] res_m, frame_word, cap;
  integer ncap;

  always @(posedge clk) begin
    if (!rst_n) begin
      n = 0; f0 = -1000000; conv_end = -1; busy_end = -1;
      mode_m = 0; exp_busy = 0; exp_shift = 0; prev_shift = 0;
      res_m = '0; frame_word = '0; cap = '0; ncap = 0; raw_prev = 0; clean = 1;
    end else begin
      n++;
      if (n == conv_end) begin
        res_m = sample_in;
        if (!mode_m) begin f0 = n; frame_word = sample_in; end
      end
      if (start && !exp_busy && !exp_shift) begin
        mode_m   = read_during;
        conv_end = n + CONV;
        if (mode_m) begin
          f0 = n; frame_word = res_m; busy_end = n + CONV;
        end else begin
          busy_end = n + CONV + FRAME;
        end
      end
      prev_shift = exp_shift;
      exp_busy   = (n < busy_end);
      exp_shift  = (n >= f0) && (n < f0 + FRAME);
      e_raw = exp_shift && (((n - f0) % DIV) >= DIV / 2);
      e_bit = exp_shift && frame_word[15 - (n - f0) / DIV];
    end
    #1;
    if (rst_n && !done) begin
      chk(busy == exp_busy, "R1 R4 R5 R6 R10 busy", busy, exp_busy);
      chk(sclk == (((!cs_rd_n) && e_raw) ^ inv_sclk), "R3 R7 R8 sclk", sclk,
          ((!cs_rd_n) && e_raw) ^ inv_sclk);
      chk(sync == (((!cs_rd_n) && exp_shift) ^ inv_sync), "R2 R7 R8 sync", sync,
          ((!cs_rd_n) && exp_shift) ^ inv_sync);
      chk(sdout == ((!cs_rd_n) && e_bit), "R2 R3 R8 sdout", sdout, (!cs_rd_n) && e_bit);
      // R2: word seen at the pins on active clock edges
      if (exp_shift && !prev_shift) begin ncap = 0; cap = '0; clean = 1; end
      if (cs_rd_n) clean = 0;
      if (!cs_rd_n && (sclk ^ inv_sclk) && !raw_prev && (sync ^ inv_sync)) begin
        cap = {cap[14:0], sdout}; ncap++;
      end
      raw_prev = sclk ^ inv_sclk;
      if (prev_shift && !exp_shift && clean)
        chk(cap == frame_word && ncap == 16, "R2 captured word", cap, frame_word);
    end
  end

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic wait_clks(input int k);
    repeat (k) @(negedge clk);
  endtask

  initial begin
    rst_n = 0; start = 0; read_during = 0; inv_sclk = 0; inv_sync = 0;
    cs_rd_n = 0; sample_in = 16'hA5C3;
    wait_clks(3);
    // R9 reset state
    chk(busy == 0, "R9 busy in reset", busy, 0);
    chk(sdout == 0, "R9 sdout in reset", sdout, 0);
    chk(sclk == 0 && sync == 0, "R9 idle levels", {sclk, sync}, 0);
    inv_sclk = 1; inv_sync = 1;
    wait_clks(1);
    chk(sclk == 1 && sync == 1, "R9 inverted idle levels", {sclk, sync}, 3);
    inv_sclk = 0; inv_sync = 0;
    wait_clks(1);
    rst_n = 1;
    wait_clks(2);

    // R4 read-after, with an ignored start (R6)
    pulse_start();
    wait_clks(8);
    pulse_start();
    wait_clks(CONV + FRAME + 6);

    // R5 read-during: shifts A5C3 while converting 3C5A; R6 start in frame; R10 mode flip
    read_during = 1; sample_in = 16'h3C5A;
    pulse_start();
    wait_clks(6);
    read_during = 0;
    wait_clks(CONV);
    pulse_start();
    wait_clks(FRAME);
    read_during = 1; sample_in = 16'h8001;
    pulse_start();
    wait_clks(FRAME + 6);

    // R7 polarity combinations, read-after
    inv_sclk = 1; inv_sync = 0; read_during = 0; sample_in = 16'h7FFE;
    pulse_start();
    wait_clks(CONV + FRAME + 6);
    inv_sclk = 0; inv_sync = 1; sample_in = 16'hFFFF;
    pulse_start();
    wait_clks(CONV + FRAME + 6);
    inv_sync = 0;

    // R8 read gate dropped mid-frame
    inv_sclk = 1; sample_in = 16'h0F0F;
    pulse_start();
    wait_clks(CONV + 10);
    cs_rd_n = 1;
    wait_clks(20);
    cs_rd_n = 0;
    wait_clks(FRAME + 6);
    inv_sclk = 0;
    // R8 gate high for a whole frame, read-during
    read_during = 1; cs_rd_n = 1; sample_in = 16'h1111;
    pulse_start();
    wait_clks(FRAME + 6);
    cs_rd_n = 0;
    wait_clks(4);

    done = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule